// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit integers over several clock cycles and returns the full 2*WIDTH-bit product. A start pulse while the block is idle captures both operands. The multiplicand goes into its own register. The multiplier goes into the lower half of a single double-width product register, and the upper half starts at zero.

On each working cycle the low bit of the product register decides the step. If it is set, a WIDTH-bit adder adds the fixed multiplicand into the upper half. The whole register, together with the adder's carry, then moves right by one place, so the multiplier is used up as the product builds. After WIDTH such steps the upper half holds the high word and the lower half holds the low word. A one-cycle done pulse marks the end, and the result then stays in place until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and prod_hi_o and prod_lo_o are 0.
- R2: A start_i sampled high while busy_o is 0 makes busy_o go high on the next cycle, and it stays high for exactly WIDTH cycles.
- R3: done_o is high for exactly one cycle: the cycle right after the last busy cycle. It is never high while busy_o is high.
- R4: When done_o is high, {prod_hi_o, prod_lo_o} equals the unsigned product of the captured operands. prod_hi_o is bits 2*WIDTH-1 down to WIDTH and prod_lo_o is bits WIDTH-1 down to 0.
- R5: No adder carry is lost. All-ones times all-ones gives high word all-ones minus one and low word 1, for example 0xFFFFFFFE and 0x00000001 at WIDTH=32.
- R6: A start_i pulse while busy_o is high has no effect. The running operation keeps its operands and its timing.
- R7: While idle and with no start, the result outputs hold their value, whatever the operand inputs do.
- R8: Operand inputs are sampled only on the cycle a start is accepted. Changes to them afterwards do not affect the result.
- R9: A start given in the same cycle that done_o is high is accepted and begins a new operation.
- R10: With WIDTH=4, 2 times 3 gives high word 0 and low word 6, and 15 times 15 gives high word 0xE and low word 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | High while the iterations run |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| prod_hi_o | output | WIDTH | High word of the product |
| prod_lo_o | output | WIDTH | Low word of the product |

## Verification
The bench uses all-ones operands at both widths. A design that dropped the adder carry during the shift would return a high word that is too small.

The bench pulses start in the middle of a run with different operands. It also changes the operand inputs right after every start. A design that reloaded its registers, or read the inputs live, would give a product of the wrong operands or a busy window of the wrong length.

The bench times the busy window and the done pulse to the exact cycle. It also starts a new operation in the done cycle itself, which catches an off-by-one iteration count and a controller that misses a back-to-back start.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  assign sum_o = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WIDTH + 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(WIDTH - 1));
  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;

  assign addend = prod_q[0] ? mcand_q : '0;

  mul_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i  (prod_q[PW-1:WIDTH]),
    .b_i  (addend),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      // carry becomes the new MSB; multiplier bit 0 falls off the right
      prod_q <= {sum, prod_q[WIDTH-1:1]};
    end
  end

  assign hi_o = prod_q[PW-1:WIDTH];
  assign lo_o = prod_q[WIDTH-1:0];
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] prod_hi_o,
  output logic [WIDTH-1:0] prod_lo_o
);
  logic load, step;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .hi_o    (prod_hi_o),
    .lo_o    (prod_lo_o)
  );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] prod_hi_o,
  input logic [WIDTH-1:0] prod_lo_o
);
  localparam int CW = $clog2(WIDTH + 1) + 1;
  localparam int PW = 2 * WIDTH;

  logic [CW-1:0] busy_cnt_q;
  logic [PW-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      ref_q      <= '0;
    end else begin
      busy_cnt_q <= busy_o ? busy_cnt_q + 1'b1 : '0;
      if (start_i && !busy_o)
        ref_q <= PW'(mcand_i) * PW'(mplier_i);
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt_q == CW'(WIDTH)));

  assert_busy_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt_q < CW'(WIDTH)));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($fell(busy_o) && !busy_o));

  assert_product_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({prod_hi_o, prod_lo_o} == ref_q));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({prod_hi_o, prod_lo_o}));
endmodule

bind shift_add_mul mul_checker #(.WIDTH(WIDTH)) u_mul_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .prod_hi_o(prod_hi_o),
  .prod_lo_o(prod_lo_o)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mcand = '0, mplier = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  logic        start4 = 1'b0;
  logic [3:0]  mcand4 = '0, mplier4 = '0;
  logic        busy4, done4;
  logic [3:0]  hi4, lo4;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mul #(.WIDTH(32)) u_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .prod_hi_o(hi), .prod_lo_o(lo));

  shift_add_mul #(.WIDTH(4)) u_mul4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start4), .mcand_i(mcand4), .mplier_i(mplier4),
    .busy_o(busy4), .done_o(done4), .prod_hi_o(hi4), .prod_lo_o(lo4));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller is at a negedge. disturb pulses start with other operands mid-run.
  task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit disturb, input string req);
    logic [63:0] exp;
    int bc;
    bit seen;
    exp = {32'h0, a} * {32'h0, b};
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = 32'hDEAD_BEEF; mplier = 32'h1234_5678;  // R8
    bc = 0; seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin seen = 1'b1; break; end
      if (busy) bc++;
      if (disturb && bc == 5) begin
        start = 1'b1; mcand = ~a; mplier = ~b;  // R6
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(seen && !busy, {req, " R3 done seen"}, {62'h0, busy, seen}, 64'h1);
    chk(bc == 32, {req, " R2 busy cycles"}, 64'(bc), 64'd32);
    chk({hi, lo} == exp, {req, " R4 product"}, {hi, lo}, exp);
  endtask

  task automatic check_done_drop(input string req);
    @(negedge clk);
    chk(!done && !busy, {req, " R3 single pulse"}, {62'h0, busy, done}, 64'h0);
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R1 flags", {62'h0, busy, done}, 64'h0);
    chk({hi, lo} == 64'h0, "R1 product", {hi, lo}, 64'h0);
    chk(!busy4 && {hi4, lo4} == 8'h0, "R1 narrow", {55'h0, busy4, hi4, lo4}, 64'h0);
  endtask

  task automatic t_basic;
    run32(32'd7, 32'd9, 1'b0, "basic");
    check_done_drop("basic");
    run32(32'h0, 32'hFFFF_FFFF, 1'b0, "zero");
    check_done_drop("zero");
    run32(32'h8000_0001, 32'hC000_0003, 1'b0, "wide");
    check_done_drop("wide");
    run32(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "mixed");
    check_done_drop("mixed");
  endtask

  task automatic t_allones;
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 allones");
    chk(hi == 32'hFFFF_FFFE && lo == 32'h1, "R5 carry kept", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
    check_done_drop("R5");
  endtask

  task automatic t_start_busy;
    run32(32'h0000_ABCD, 32'h0001_0003, 1'b1, "R6 start while busy");
    check_done_drop("R6");
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    run32(32'd1000, 32'd3000, 1'b0, "R7 pre");
    keep = {hi, lo};
    for (int i = 0; i < 6; i++) begin
      mcand = 32'(i * 77 + 5); mplier = ~32'(i);
      @(negedge clk);
    end
    chk({hi, lo} == keep && !busy, "R7 hold idle", {hi, lo}, keep);
  endtask

  task automatic t_back_to_back;
    run32(32'd11, 32'd13, 1'b0, "R9 first");
    // still in the done cycle: start again at once
    run32(32'hFFFF_0000, 32'h0000_FFFF, 1'b0, "R9 second");
    check_done_drop("R9");
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp, input string req);
    bit seen;
    mcand4 = a; mplier4 = b; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0; mcand4 = 4'h9; mplier4 = 4'h6;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done4) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, {req, " done"}, {63'h0, seen}, 64'h1);
    chk({hi4, lo4} == exp, {req, " product"}, {56'h0, hi4, lo4}, {56'h0, exp});
    @(negedge clk);
  endtask

  task automatic t_narrow;
    run4(4'd2, 4'd3, 8'h06, "R10 2x3");
    run4(4'hF, 4'hF, 8'hE1, "R10 R5 15x15");
    run4(4'hA, 4'h7, 8'h46, "R10 10x7");
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #80000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_allones();
    t_start_busy();
    t_hold();
    t_back_to_back();
    t_narrow();
    summary();
  end
endmodule